// File: doc/BRIEF.md
# Midpoint Texture Integer Stepper

This block follows the integer part of a perspective-correct texture coordinate while a pixel traversal walks across a triangle one pixel at a time. Mathematically the tracked value is u = floor(N/D) with N = Kx+Ly+M and D = Rx+Sy+T, but the block never divides. It keeps four running terms: a doubled denominator d = 2D, an error term e = u·d − 2N, and two per-axis increments a = 2uR − 2K and b = 2uS − 2L. A pixel step adds a fixed amount to d and adds (or subtracts) a or b to e. A small fixed adder array then pulls u back into range, by up to two units up or down, in the same cycle.

A setup stage loads the starting u and terms together with the constants 2R and 2S. The traversal then issues one step code per cycle. The corrected u is registered and appears one clock after the step. A two-state machine governs the block. ST_IDLE is the state after reset, and steps are ignored there. The transition IDLE→TRACK is taken on a load. In ST_TRACK the block stays in ST_TRACK on every step, hold or reload (TRACK→TRACK). Only reset leaves ST_TRACK.

Top module: `midtex_stepper`

## Requirements
- R1: After reset, u_out is 0 and u_valid is 0 (state ST_IDLE).
- R2: When load is high at a clock edge, u_out equals ld_u and u_valid is 1 from the next cycle on. This holds in both states.
- R3: step_op = 2'b01 moves one pixel to +x. One cycle later u_out equals floor(N/D) at the new pixel.
- R4: step_op = 2'b10 moves one pixel to −x. One cycle later u_out equals floor(N/D) at the new pixel.
- R5: step_op = 2'b11 moves one pixel to +y. One cycle later u_out equals floor(N/D) at the new pixel.
- R6: step_op = 2'b00 in ST_TRACK leaves u_out unchanged.
- R7: In ST_IDLE, step codes without a load are ignored: u_out stays 0 and u_valid stays 0.
- R8: A single step corrects u by as much as +2 or −2. Negative values of u are tracked in two's complement.
- R9: If load and a non-hold step code occur in the same cycle, the load wins. u_out then equals ld_u, not a stepped value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load | input | 1 | Initialize all terms from the ld_* values |
| ld_u | input | UW | Starting integer u |
| ld_d | input | W | Starting d = 2D |
| ld_e | input | W | Starting e = u·d − 2N |
| ld_a | input | W | Starting a = 2uR − 2K |
| ld_b | input | W | Starting b = 2uS − 2L |
| two_r | input | W | Constant 2R, held for the whole traversal |
| two_s | input | W | Constant 2S, held for the whole traversal |
| step_op | input | 2 | 00 hold, 01 +x, 10 −x, 11 +y |
| u_out | output | UW | Tracked integer u (two's complement) |
| u_valid | output | 1 | High in ST_TRACK |

## Verification
The assertions take three things for granted. The loaded terms must be consistent, so that −d < e ≤ 0 holds with d > 0. The denominator must stay positive across the traversal. The exact change of u per step must be at most two. The stimulus keeps within these limits by deriving every load value arithmetically from the coefficient set at the start pixel. The coefficient sets are picked so that D stays positive over the swept grid and the slope of N/D never exceeds two per pixel. One set has a slope of exactly ±2 per pixel, so the largest correction is exercised on every step.

// File: rtl/midtex_pkg.sv
package midtex_pkg;

    typedef enum logic [1:0] {
        OP_HOLD  = 2'b00,
        OP_RIGHT = 2'b01,
        OP_LEFT  = 2'b10,
        OP_DOWN  = 2'b11
    } step_op_t;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_TRACK = 1'b1
    } track_state_t;

endpackage

// File: rtl/midtex_move.sv
// Applies one pixel move to the denominator and error terms.
module midtex_move
    import midtex_pkg::*;
#(
    parameter int W = 24
) (
    input  step_op_t          op,
    input  logic signed [W-1:0] d_in,
    input  logic signed [W-1:0] e_in,
    input  logic signed [W-1:0] a_in,
    input  logic signed [W-1:0] b_in,
    input  logic signed [W-1:0] two_r,
    input  logic signed [W-1:0] two_s,
    output logic signed [W-1:0] d_out,
    output logic signed [W-1:0] e_out
);

    always_comb begin
        d_out = d_in;
        e_out = e_in;
        unique case (op)
            OP_HOLD: begin
                d_out = d_in;
                e_out = e_in;
            end
            OP_RIGHT: begin
                d_out = d_in + two_r;
                e_out = e_in + a_in;
            end
            OP_LEFT: begin
                d_out = d_in - two_r;
                e_out = e_in - a_in;
            end
            OP_DOWN: begin
                d_out = d_in + two_s;
                e_out = e_in + b_in;
            end
        endcase
    end

endmodule

// File: rtl/midtex_fix.sv
// Pulls the error term back into (-d, 0] by adjusting u by 0, +-1 or +-2.
module midtex_fix #(
    parameter int W     = 24,
    parameter int UW    = 12,
    parameter int NCAND = 2
) (
    input  logic signed [W-1:0]  d_in,
    input  logic signed [W-1:0]  e_in,
    input  logic signed [W-1:0]  a_in,
    input  logic signed [W-1:0]  b_in,
    input  logic signed [W-1:0]  two_r,
    input  logic signed [W-1:0]  two_s,
    input  logic signed [UW-1:0] u_in,
    output logic signed [W-1:0]  e_out,
    output logic signed [W-1:0]  a_out,
    output logic signed [W-1:0]  b_out,
    output logic signed [UW-1:0] u_out
);

    localparam int MW = $clog2(NCAND + 1);

    logic signed [W-1:0] e_neg;
    logic                lower;
    logic signed [W-1:0] cand [1:NCAND];
    logic [MW-1:0]       mag;

    // Sign of the negated error decides the direction of every adder.
    assign e_neg = -e_in;
    assign lower = e_neg[W-1];

    for (genvar g = 1; g <= NCAND; g++) begin : g_cand
        logic signed [W-1:0] mult_d;
        assign mult_d  = d_in <<< (g - 1);
        assign cand[g] = lower ? (e_in - mult_d) : (e_in + mult_d);
    end

    // Decision from the signs of the candidates and the unchanged error.
    always_comb begin
        if (lower) begin
            mag = (cand[1] <= 0) ? MW'(1) : MW'(2);
        end else if (cand[1] > 0) begin
            mag = MW'(0);
        end else if (cand[2] > 0) begin
            mag = MW'(1);
        end else begin
            mag = MW'(2);
        end
    end

    function automatic logic signed [W-1:0] scaled(input logic signed [W-1:0] v,
                                                   input logic [MW-1:0] m,
                                                   input logic dn);
        logic signed [W-1:0] t;
        case (m)
            MW'(0):  t = '0;
            MW'(1):  t = v;
            default: t = v <<< 1;
        endcase
        return dn ? -t : t;
    endfunction

    always_comb begin
        case (mag)
            MW'(0):  e_out = e_in;
            MW'(1):  e_out = cand[1];
            default: e_out = cand[2];
        endcase
        a_out = a_in + scaled(two_r, mag, lower);
        b_out = b_in + scaled(two_s, mag, lower);
        u_out = lower ? (u_in - UW'(mag)) : (u_in + UW'(mag));
    end

endmodule

// File: rtl/midtex_stepper.sv
module midtex_stepper
    import midtex_pkg::*;
#(
    parameter int W  = 24,
    parameter int UW = 12
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 load,
    input  logic signed [UW-1:0] ld_u,
    input  logic signed [W-1:0]  ld_d,
    input  logic signed [W-1:0]  ld_e,
    input  logic signed [W-1:0]  ld_a,
    input  logic signed [W-1:0]  ld_b,
    input  logic signed [W-1:0]  two_r,
    input  logic signed [W-1:0]  two_s,
    input  logic [1:0]           step_op,
    output logic signed [UW-1:0] u_out,
    output logic                 u_valid
);

    localparam logic signed [UW-1:0] U_MAX_STEP = UW'(2);

    track_state_t st_q, st_d;
    step_op_t     op;

    logic signed [UW-1:0] u_q, u_fix;
    logic signed [W-1:0]  d_q, e_q, a_q, b_q;
    logic signed [W-1:0]  d_mv, e_mv, e_fix, a_fix, b_fix;
    logic                 do_step;

    assign op      = step_op_t'(step_op);
    assign do_step = (st_q == ST_TRACK) && !load && (op != OP_HOLD);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:  if (load) st_d = ST_TRACK;
            ST_TRACK: st_d = ST_TRACK;
        endcase
    end

    // Outputs
    always_comb begin
        u_out   = u_q;
        u_valid = (st_q == ST_TRACK);
    end

    midtex_move #(.W(W)) i_move (
        .op    (op),
        .d_in  (d_q),
        .e_in  (e_q),
        .a_in  (a_q),
        .b_in  (b_q),
        .two_r (two_r),
        .two_s (two_s),
        .d_out (d_mv),
        .e_out (e_mv)
    );

    midtex_fix #(.W(W), .UW(UW)) i_fix (
        .d_in  (d_mv),
        .e_in  (e_mv),
        .a_in  (a_q),
        .b_in  (b_q),
        .two_r (two_r),
        .two_s (two_s),
        .u_in  (u_q),
        .e_out (e_fix),
        .a_out (a_fix),
        .b_out (b_fix),
        .u_out (u_fix)
    );

    // Term registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            u_q <= '0;
            d_q <= '0;
            e_q <= '0;
            a_q <= '0;
            b_q <= '0;
        end else if (load) begin
            u_q <= ld_u;
            d_q <= ld_d;
            e_q <= ld_e;
            a_q <= ld_a;
            b_q <= ld_b;
        end else if (do_step) begin
            u_q <= u_fix;
            d_q <= d_mv;
            e_q <= e_fix;
            a_q <= a_fix;
            b_q <= b_fix;
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (st_q == ST_IDLE && u_q == '0)); // R1
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (u_q == $past(ld_u) && st_q == ST_TRACK)); // R9
    AST_ERR_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK) |-> (e_q <= 0 && (e_q + d_q) > 0)); // R3
    AST_STEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        do_step |=> ((u_q - $past(u_q)) <= U_MAX_STEP && (u_q - $past(u_q)) >= -U_MAX_STEP)); // R8
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_TRACK && !load && op == OP_HOLD) |=> ($stable(u_q) && $stable(e_q))); // R6
    AST_IDLE_IGNORES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_IDLE && !load) |=> (u_q == '0 && st_q == ST_IDLE)); // R7

endmodule

// File: tb/test_midtex_stepper.sv
`timescale 1ns/1ps
module test_midtex_stepper;

    localparam int BW = 24;
    localparam int BU = 12;
    localparam int NX = 8;
    localparam int NY = 6;
    localparam int NSET = 4;

    logic                  clk = 1'b0;
    logic                  rst_n;
    logic                  load;
    logic signed [BU-1:0]  ld_u;
    logic signed [BW-1:0]  ld_d, ld_e, ld_a, ld_b, two_r, two_s;
    logic [1:0]            step_op;
    logic signed [BU-1:0]  u_out;
    logic                  u_valid;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    midtex_stepper #(.W(BW), .UW(BU)) i_midtex_stepper (
        .clk(clk), .rst_n(rst_n), .load(load), .ld_u(ld_u), .ld_d(ld_d),
        .ld_e(ld_e), .ld_a(ld_a), .ld_b(ld_b), .two_r(two_r), .two_s(two_s),
        .step_op(step_op), .u_out(u_out), .u_valid(u_valid)
    );

    // Coefficient sets: R, S, T, K, L, M
    int cr[NSET] = '{1, -1, 0, 0};
    int cs[NSET] = '{2, 1, 0, 0};
    int ct[NSET] = '{40, 60, 8, 1};
    int ck[NSET] = '{30, -25, 15, 2};
    int cl[NSET] = '{-20, 40, -12, -2};
    int cm[NSET] = '{100, -300, 0, 5};

    function automatic int fdiv(input int n, input int d);
        int q;
        q = n / d;
        if ((n % d != 0) && ((n < 0) != (d < 0))) q = q - 1;
        return q;
    endfunction

    function automatic int expect_u(input int s, input int x, input int y);
        return fdiv(ck[s]*x + cl[s]*y + cm[s], cr[s]*x + cs[s]*y + ct[s]);
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_step(input logic [1:0] op, input int exp, input string req);
        step_op = op;
        @(negedge clk);
        step_op = 2'b00;
        chk(req, int'(u_out), exp);
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; load = 1'b0; step_op = 2'b00;
        ld_u = '0; ld_d = '0; ld_e = '0; ld_a = '0; ld_b = '0;
        two_r = '0; two_s = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", int'(u_out), 0);
        chk("R1", int'(u_valid), 0);

        // R7: steps before any load are ignored
        step_op = 2'b01;
        @(negedge clk);
        chk("R7", int'(u_out), 0);
        step_op = 2'b11;
        @(negedge clk);
        step_op = 2'b00;
        chk("R7", int'(u_out), 0);
        chk("R7", int'(u_valid), 0);

        for (int s = 0; s < NSET; s++) begin
            int u0, x, y;
            u0 = fdiv(cm[s], ct[s]);
            ld_u  = BU'(u0);
            ld_d  = BW'(2 * ct[s]);
            ld_e  = BW'(u0 * 2 * ct[s] - 2 * cm[s]);
            ld_a  = BW'(2 * u0 * cr[s] - 2 * ck[s]);
            ld_b  = BW'(2 * u0 * cs[s] - 2 * cl[s]);
            two_r = BW'(2 * cr[s]);
            two_s = BW'(2 * cs[s]);
            load = 1'b1;
            if (s == 1) step_op = 2'b01;   // R9: load beats step
            @(negedge clk);
            load = 1'b0;
            step_op = 2'b00;
            chk((s == 1) ? "R9" : "R2", int'(u_out), u0);
            chk("R2", int'(u_valid), 1);
            @(negedge clk);
            chk("R6", int'(u_out), u0);

            x = 0;
            y = 0;
            for (int row = 0; row < NY; row++) begin
                for (int i = 1; i < NX; i++) begin
                    if (row % 2 == 0) begin
                        x = x + 1;
                        do_step(2'b01, expect_u(s, x, y), (s >= 2) ? "R8" : "R3");
                    end else begin
                        x = x - 1;
                        do_step(2'b10, expect_u(s, x, y), (s >= 2) ? "R8" : "R4");
                    end
                end
                if (row < NY - 1) begin
                    y = y + 1;
                    do_step(2'b11, expect_u(s, x, y), (s >= 2) ? "R8" : "R5");
                end
            end
            @(negedge clk);
            chk("R6", int'(u_out), expect_u(s, x, y));
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule